// File: doc/BRIEF.md
# Variable-Rate Sinc Decimation Filter

This block takes a narrow oversampled stream from a delta-sigma modulator and averages it with a cascaded integrator-comb sinc filter. The default filter is third order. After the filter, an offset is subtracted and a fixed-point gain is applied, with saturation to the output width. A one-cycle data-ready strobe then marks each result. The output word rate is the modulator sample rate divided by the decimation ratio.

The decimation ratio is an unsigned fixed-point number with an integer part and a fractional part. A phase accumulator gains one unit for each accepted modulator sample. When the accumulator reaches the ratio, an output boundary occurs and the remainder is kept, so a non-integer ratio yields boundaries whose spacing alternates between the two nearest whole counts. The ratio can be rewritten at any time. A new value is loaded at the next output boundary, and the filter is not flushed, so the output stream has no gap. A system controller uses this to stretch or shorten a few output periods and pull its sampling instants back into line with a shared time mark.

A separate filter-reset input discards all accumulated samples and filter state. The data-ready strobe then stays low until the filter has settled again.

Top module: `var_sinc_decim`

## Requirements
- R1: With an integer ratio M and a sample on every cycle, drdy_o pulses for exactly one cycle once every M accepted samples.
- R2: With ratio M, gain 1.0 (16384) and offset 0, every settled output equals the mean input value multiplied by M cubed. A constant 1 at ratio 4 gives 64. A 1,0,1,0 pattern at ratio 4 gives 32.
- R3: The ratio is {int, frac}, with FRAC_W fractional bits. Each accepted sample adds 2^FRAC_W to the phase. A boundary occurs when the phase is at least the ratio, and the remainder is kept. A ratio of 2.5 therefore gives boundaries spaced 2 and 3 samples apart, 16 boundaries in 40 samples.
- R4: A ratio written between boundaries does not reset the filter. The current period finishes at the old ratio and the following periods use the new one, with no gap in drdy_o.
- R5: A written ratio below 2.0 is stored as exactly 2.0.
- R6: After filt_rst_i, the first three output boundaries (the filter order) give no drdy_o. The fourth gives a correct settled value.
- R7: data_o is floor(((filter_out - offset_i) * gain_i) / 2^14). The gain is unsigned, with 14 fractional bits, and the result is signed.
- R8: A corrected value beyond the signed OUT_W range is clamped to 2^(OUT_W-1)-1 or to -2^(OUT_W-1).
- R9: A cycle with mod_valid_i low is ignored. It neither integrates data nor advances the phase.
- R10: After rst_ni is released, drdy_o and data_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| filt_rst_i | input | 1 | Synchronous filter flush |
| mod_valid_i | input | 1 | Qualifies mod_data_i |
| mod_data_i | input | IN_W | Unsigned modulator sample |
| ratio_wr_i | input | 1 | Ratio write strobe |
| ratio_int_i | input | INT_W | Integer part of the ratio |
| ratio_frac_i | input | FRAC_W | Fractional part of the ratio |
| offset_i | input | ACC_W+1 | Signed offset subtracted from the filter output |
| gain_i | input | GAIN_W | Unsigned gain, with GAIN_FRAC fractional bits |
| data_o | output | OUT_W | Signed corrected result |
| drdy_o | output | 1 | One-cycle result strobe |

## Verification
The bench rewrites the ratio in the middle of a period and then checks that the remaining boundaries are spaced at the new value. It also checks that the fourth output after the change reads exactly 512. A design that applied the write at once, or flushed the filter, would shift the pulse train or lose pulses.

The fractional ratio of 2.5 must give spacings of only 2 and 3 samples and the exact boundary count. A design that dropped the phase remainder would run at a flat 2 or 3.

The other corner cases cover:
- the settle count after a flush, where one pulse too many or too few is caught;
- ratios written below the floor;
- gaps in the sample qualifier;
- rounding toward minus infinity for a result of -0.5;
- clamping in both directions.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  typedef enum logic {
    ST_SETTLE = 1'b0,
    ST_RUN    = 1'b1
  } settle_e;

  localparam int unsigned RATIO_FLOOR_INT = 2;
endpackage

// File: rtl/vsd_phase.sv
module vsd_phase #(
  parameter int INT_W   = 8,
  parameter int FRAC_W  = 8,
  parameter int DEF_INT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sample_i,
  input  logic              wr_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              tick_o
);
  localparam int R_W  = INT_W + FRAC_W;
  localparam int PH_W = R_W + 1;
  localparam logic [R_W-1:0]  FLOOR = R_W'(vsd_pkg::RATIO_FLOOR_INT) << FRAC_W;
  localparam logic [R_W-1:0]  DEF   = R_W'(DEF_INT) << FRAC_W;
  localparam logic [PH_W-1:0] ONE   = PH_W'(1) << FRAC_W;

  logic [R_W-1:0]  wr_val, pend_q, act_q, next_ratio;
  logic [PH_W-1:0] phase_q, phase_sum;

  always_comb begin
    wr_val = {int_i, frac_i};
    if (wr_val < FLOOR) wr_val = FLOOR;
    // a write in the boundary cycle still lands at that boundary
    next_ratio = wr_i ? wr_val : pend_q;
    phase_sum  = phase_q + ONE;
    tick_o     = sample_i && !clr_i && (phase_sum >= {1'b0, act_q});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= DEF;
      act_q   <= DEF;
      phase_q <= '0;
    end else begin
      if (wr_i) pend_q <= wr_val;
      if (clr_i) begin
        phase_q <= '0;
        act_q   <= next_ratio;
      end else if (sample_i) begin
        if (tick_o) begin
          phase_q <= phase_sum - {1'b0, act_q};
          act_q   <= next_ratio;
        end else begin
          phase_q <= phase_sum;
        end
      end
    end
  end

  assert_phase_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q < {1'b0, act_q});
  assert_ratio_at_boundary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_o || clr_i) |=> $stable(act_q));
  assert_ratio_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q >= FLOOR);
endmodule

// File: rtl/vsd_cic.sv
module vsd_cic #(
  parameter int IN_W  = 1,
  parameter int ORDER = 3,
  parameter int ACC_W = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             sample_i,
  input  logic [IN_W-1:0]  data_i,
  input  logic             tick_i,
  output logic [ACC_W-1:0] cic_o
);
  logic [ACC_W-1:0] x_ext;
  logic [ACC_W-1:0] integ_q [ORDER];
  logic [ACC_W-1:0] dly_q   [ORDER];
  logic [ACC_W-1:0] comb_d  [ORDER+1];

  assign x_ext = ACC_W'(data_i);

  // integrators run at the modulator rate; wrap-around is exact modulo 2^ACC_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < ORDER; g++) integ_q[g] <= '0;
    end else if (clr_i) begin
      for (int g = 0; g < ORDER; g++) integ_q[g] <= '0;
    end else if (sample_i) begin
      integ_q[0] <= integ_q[0] + x_ext;
      for (int g = 1; g < ORDER; g++) integ_q[g] <= integ_q[g] + integ_q[g-1];
    end
  end

  for (genvar g = 0; g < ORDER; g++) begin : gen_comb
    assign comb_d[g+1] = comb_d[g] - dly_q[g];
  end
  assign comb_d[0] = integ_q[ORDER-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < ORDER; g++) dly_q[g] <= '0;
      cic_o <= '0;
    end else if (clr_i) begin
      for (int g = 0; g < ORDER; g++) dly_q[g] <= '0;
      cic_o <= '0;
    end else if (tick_i) begin
      for (int g = 0; g < ORDER; g++) dly_q[g] <= comb_d[g];
      cic_o <= comb_d[ORDER];
    end
  end

  assert_cic_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_i && !clr_i) |=> $stable(integ_q[0]));
endmodule

// File: rtl/vsd_corr.sv
module vsd_corr #(
  parameter int ACC_W     = 25,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 14,
  parameter int OUT_W     = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    vld_i,
  input  logic [ACC_W-1:0]        cic_i,
  input  logic signed [ACC_W:0]   offset_i,
  input  logic [GAIN_W-1:0]       gain_i,
  output logic [OUT_W-1:0]        data_o,
  output logic                    drdy_o
);
  localparam int DIF_W  = ACC_W + 2;
  localparam int PROD_W = DIF_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] SAT_HI = {{(PROD_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] SAT_LO = {{(PROD_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [DIF_W-1:0]  diff;
  logic signed [PROD_W-1:0] prod, scaled;
  logic [OUT_W-1:0]         sat_val;

  always_comb begin
    diff   = $signed({2'b00, cic_i}) - DIF_W'(offset_i);
    prod   = PROD_W'(diff) * $signed({{(PROD_W-GAIN_W){1'b0}}, gain_i});
    scaled = prod >>> GAIN_FRAC;
    if (scaled > SAT_HI)      sat_val = SAT_HI[OUT_W-1:0];
    else if (scaled < SAT_LO) sat_val = SAT_LO[OUT_W-1:0];
    else                      sat_val = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      drdy_o <= 1'b0;
    end else begin
      drdy_o <= vld_i && !clr_i;
      if (vld_i && !clr_i) data_o <= sat_val;
    end
  end

  assert_data_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(data_o));
endmodule

// File: rtl/var_sinc_decim.sv
module var_sinc_decim #(
  parameter int IN_W      = 1,
  parameter int ORDER     = 3,
  parameter int INT_W     = 8,
  parameter int FRAC_W    = 8,
  parameter int DEF_INT   = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 14,
  parameter int OUT_W     = 24,
  localparam int ACC_W    = IN_W + ORDER * INT_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  filt_rst_i,
  input  logic                  mod_valid_i,
  input  logic [IN_W-1:0]       mod_data_i,
  input  logic                  ratio_wr_i,
  input  logic [INT_W-1:0]      ratio_int_i,
  input  logic [FRAC_W-1:0]     ratio_frac_i,
  input  logic signed [ACC_W:0] offset_i,
  input  logic [GAIN_W-1:0]     gain_i,
  output logic [OUT_W-1:0]      data_o,
  output logic                  drdy_o
);
  import vsd_pkg::*;
  localparam int CNT_W = $clog2(ORDER + 1);

  logic             tick, cic_vld;
  logic [ACC_W-1:0] cic_out;
  logic [CNT_W-1:0] settle_cnt;
  settle_e          st_q;

  vsd_phase #(.INT_W(INT_W), .FRAC_W(FRAC_W), .DEF_INT(DEF_INT)) u_phase (
    .clk_i, .rst_ni, .clr_i(filt_rst_i), .sample_i(mod_valid_i),
    .wr_i(ratio_wr_i), .int_i(ratio_int_i), .frac_i(ratio_frac_i), .tick_o(tick));

  vsd_cic #(.IN_W(IN_W), .ORDER(ORDER), .ACC_W(ACC_W)) u_cic (
    .clk_i, .rst_ni, .clr_i(filt_rst_i), .sample_i(mod_valid_i),
    .data_i(mod_data_i), .tick_i(tick), .cic_o(cic_out));

  // the first ORDER boundaries after a flush carry stale comb history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_SETTLE;
      settle_cnt <= '0;
      cic_vld    <= 1'b0;
    end else if (filt_rst_i) begin
      st_q       <= ST_SETTLE;
      settle_cnt <= '0;
      cic_vld    <= 1'b0;
    end else begin
      cic_vld <= tick && (st_q == ST_RUN);
      if (tick && st_q == ST_SETTLE) begin
        settle_cnt <= settle_cnt + 1'b1;
        if (settle_cnt == CNT_W'(ORDER - 1)) st_q <= ST_RUN;
      end
    end
  end

  vsd_corr #(.ACC_W(ACC_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .OUT_W(OUT_W)) u_corr (
    .clk_i, .rst_ni, .clr_i(filt_rst_i), .vld_i(cic_vld), .cic_i(cic_out),
    .offset_i, .gain_i, .data_o, .drdy_o);

  assert_drdy_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cic_vld && !filt_rst_i) |=> drdy_o);
  assert_drdy_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drdy_o |=> !drdy_o);
  assert_flush_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_rst_i |=> !drdy_o);
endmodule

// File: tb/sim_var_sinc_decim.sv
module sim_var_sinc_decim;
  localparam int ACC_W = 25;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              filt_rst_i = 1'b0;
  logic              mod_valid_i = 1'b0;
  logic [0:0]        mod_data_i = '0;
  logic              ratio_wr_i = 1'b0;
  logic [7:0]        ratio_int_i = '0;
  logic [7:0]        ratio_frac_i = '0;
  logic signed [ACC_W:0] offset_i = '0;
  logic [15:0]       gain_i = 16'd16384;
  logic [23:0]       data_o;
  logic              drdy_o;

  int checks = 0, failures = 0;
  int cyc = 0, n_drdy = 0, last_val = 0, prev_cyc = -1, min_iv = 0, max_iv = 0;

  var_sinc_decim u0 (.*);

  always #4 clk_i = ~clk_i;

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic observe();
    cyc++;
    if (drdy_o) begin
      n_drdy++;
      last_val = $signed(data_o);
      if (prev_cyc >= 0) begin
        if (min_iv == 0 || cyc - prev_cyc < min_iv) min_iv = cyc - prev_cyc;
        if (cyc - prev_cyc > max_iv) max_iv = cyc - prev_cyc;
      end
      prev_cyc = cyc;
    end
  endtask

  task automatic cycle(input logic v, input logic d);
    mod_valid_i = v;
    mod_data_i  = d;
    @(negedge clk_i);
    observe();
  endtask

  task automatic clear_stats();
    n_drdy = 0; last_val = 0; prev_cyc = -1; min_iv = 0; max_iv = 0;
  endtask

  task automatic run(input int n, input int gap, input bit alt);
    for (int i = 0; i < n; i++) begin
      cycle(1'b1, alt ? ~i[0] : 1'b1);
      repeat (gap) cycle(1'b0, 1'b0);
    end
    repeat (3) cycle(1'b0, 1'b0);
  endtask

  task automatic flush();
    filt_rst_i = 1'b1;
    cycle(1'b0, 1'b0);
    filt_rst_i = 1'b0;
    clear_stats();
  endtask

  task automatic set_ratio(input int ip, input int fp);
    ratio_wr_i = 1'b1; ratio_int_i = 8'(ip); ratio_frac_i = 8'(fp);
    cycle(1'b0, 1'b0);
    ratio_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 drdy", drdy_o, 0);
    chk("R10 data", $signed(data_o), 0);
  endtask

  task automatic t_const();
    set_ratio(4, 0); flush();
    run(24, 0, 1'b0);
    chk("R2 const count", n_drdy, 3);
    chk("R2 const value", last_val, 64);
  endtask

  task automatic t_live_ratio();
    clear_stats();
    run(2, 0, 1'b0);
    set_ratio(8, 0);
    run(26, 0, 1'b0);
    chk("R4 count", n_drdy, 4);
    chk("R4 min spacing", min_iv, 8);
    chk("R4 max spacing", max_iv, 8);
    chk("R4 value", last_val, 512);
  endtask

  task automatic t_settle();
    set_ratio(4, 0); flush();
    run(12, 0, 1'b0);
    chk("R6 suppressed", n_drdy, 0);
    run(4, 0, 1'b0);
    chk("R6 first count", n_drdy, 1);
    chk("R6 first value", last_val, 64);
  endtask

  task automatic t_alt();
    flush();
    run(24, 0, 1'b1);
    chk("R2 alt count", n_drdy, 3);
    chk("R2 alt value", last_val, 32);
  endtask

  task automatic t_int_rate();
    set_ratio(6, 0); flush();
    run(48, 0, 1'b0);
    chk("R1 count", n_drdy, 5);
    chk("R1 min spacing", min_iv, 6);
    chk("R1 max spacing", max_iv, 6);
    chk("R1 value", last_val, 216);
  endtask

  task automatic t_gaps();
    set_ratio(4, 0); flush();
    run(24, 1, 1'b0);
    chk("R9 count", n_drdy, 3);
    chk("R9 spacing", max_iv, 8);
    chk("R9 value", last_val, 64);
  endtask

  task automatic t_frac();
    set_ratio(2, 128); flush();
    run(40, 0, 1'b0);
    chk("R3 count", n_drdy, 13);
    chk("R3 min spacing", min_iv, 2);
    chk("R3 max spacing", max_iv, 3);
  endtask

  task automatic t_floor();
    set_ratio(1, 128); flush();
    run(20, 0, 1'b0);
    chk("R5 count", n_drdy, 7);
    chk("R5 spacing", max_iv, 2);
    chk("R5 value", last_val, 8);
  endtask

  task automatic t_corr(input string req, input int ofs, input int g, input int exp);
    offset_i = (ACC_W+1)'(ofs);
    gain_i   = 16'(g);
    flush();
    run(16, 0, 1'b0);
    chk(req, n_drdy, 1);
    chk(req, last_val, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_const();
    t_live_ratio();
    t_settle();
    t_alt();
    t_int_rate();
    t_gaps();
    t_frac();
    t_floor();
    set_ratio(4, 0);
    t_corr("R7 half gain", 4, 8192, 30);
    t_corr("R7 negative", 100, 16384, -36);
    t_corr("R7 floor pos", 1, 8192, 31);
    t_corr("R7 floor neg", 65, 8192, -1);
    t_corr("R8 low clamp", 16777216, 16384, -8388608);
    offset_i = '0; gain_i = 16'd16384;
    set_ratio(255, 0); flush();
    run(1020, 0, 1'b0);
    chk("R8 high clamp count", n_drdy, 1);
    chk("R8 high clamp", last_val, 8388607);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule